// File: doc/BRIEF.md
# Three-Wire Control Bus Register Slave

This block is a slave on a three-wire serial control bus made of a bus clock, a mode line and a single data line. Through it, a host controller reaches a bank of 16-bit registers that lives outside the block. The block turns bus transfers into single-cycle write and read strobes on a plain register-file port. The three bus lines are asynchronous to the system clock. They pass through a synchronizer, and the system clock then detects the bus clock edges.

A transfer starts with an address phase, in which the mode line is low. In this phase the master sends one byte that selects the slave and picks an operation. The data phase follows, with the mode line high. In the data phase a write-selected slave takes a register-address byte and then the 16-bit value, high byte first. A read needs two transfers. First, a write-selected transfer sends the register address with a prepare flag set. Then a read-selected transfer shifts the stored register's value back out on the data line. The data line is driven through an output-enable signal.

Top module: `tw_reg_slave`

## Requirements
- R1: While reset is held and right after it is released, `tw_doe`, `reg_wr_en` and `reg_rd_en` are all low.
- R2: Bits are sampled on rising bus-clock edges, MSB first. An address-phase byte selects the slave when its bits [7:2] equal `{DEV_ADDR[5:1], addr_sel}` and its bits [1:0] are 2'b01 (write or prepare) or 2'b11 (read).
- R3: In a data phase after a write select, the first byte has bit 7 clear and gives the register address in bits [6:0]. The next two bytes are the high byte and then the low byte. Exactly one `reg_wr_en` pulse follows, carrying that address on `reg_addr` and the value on `reg_wdata`.
- R4: Any byte after the third in a write data phase causes no strobe.
- R5: A first data byte with bit 7 set stores bits [6:0] as the read pointer and does not write. Later bytes in that data phase cause no strobe.
- R6: When a read-selected data phase begins and a pointer is stored, one `reg_rd_en` pulse carries the pointer on `reg_addr`, and `reg_rdata` is taken in that same cycle. The value is then driven MSB first on `tw_dout`, one bit per rising bus-clock edge, and zeros follow the sixteenth bit. The pointer stays valid for later reads.
- R7: A read-selected data phase with no pointer stored since reset issues no `reg_rd_en` and drives zeros.
- R8: `tw_doe` is high only during a data phase whose preceding address byte selected the slave for read.
- R9: After an address byte with a device mismatch, or with operation code 2'b00 or 2'b10, the data phase causes no strobe and `tw_doe` stays low.
- R10: Entering the address phase drops the selection. A data phase that follows an incomplete address byte is ignored.
- R11: A change of the mode line restarts bit counting. A rising bus-clock edge seen in the same cycle as the change is the first bit of the new phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Supplies the lowest device-address bit |
| tw_clk | input | 1 | Bus clock from the master |
| tw_mode | input | 1 | Bus mode line: low for address phase, high for data phase |
| tw_din | input | 1 | Bus data line as seen by the slave |
| tw_dout | output | 1 | Read data bit to the pad |
| tw_doe | output | 1 | Pad output enable for `tw_dout` |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | 7 | Register address for either strobe |
| reg_wdata | output | 16 | Write value |
| reg_rdata | input | 16 | Read value, sampled in the `reg_rd_en` cycle |

## Verification
A phase restart and a bit capture can land in the same cycle. This happens when the mode line rises together with the bus clock's first rising edge of a data phase. The bench provokes it by switching both lines on the same system-clock edge at the start of a write. Because both lines pass through identical synchronizer stages, the receiver sees the change and the edge together. The bench judges the case by the address and value of the resulting write strobe, and by reading that register back, both compared with a model that counts the coincident bit as bit 7 of the first data byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam int DEV_W  = BYTE_W - 2;
    localparam int REG_AW = BYTE_W - 1;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_WRPREP = 2'b01,
        OP_RSVD   = 2'b10,
        OP_READ   = 2'b11
    } tw_op_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q[0] <= async_i;
                    for (int s = 1; s < STAGES; s++) begin
                        stg_q[s] <= stg_q[s-1];
                    end
                end
            end
            assign sync_o = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tw_rx.sv
module tw_rx
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mode_i,
    input  logic              data_i,
    output logic              rise_o,
    output logic              phase_o,
    output logic              mode_o,
    output logic              bvld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              bmode_o
);
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic              mode_prev;
        logic [BYTE_W-1:0] shreg;
        logic [BIT_CW-1:0] bitcnt;
        logic              rise;
        logic              phase;
        logic              bvld;
        logic [BYTE_W-1:0] bdata;
        logic              bmode;
    } rx_s;

    rx_s rx_d, rx_q;

    always_comb begin
        rx_d           = rx_q;
        rx_d.rise      = 1'b0;
        rx_d.phase     = 1'b0;
        rx_d.bvld      = 1'b0;
        rx_d.sclk_prev = sclk_i;
        rx_d.mode_prev = mode_i;
        // a mode change restarts the byte before any coincident bit is taken
        if (mode_i != rx_q.mode_prev) begin
            rx_d.phase  = 1'b1;
            rx_d.bitcnt = '0;
            rx_d.shreg  = '0;
        end
        if (sclk_i && !rx_q.sclk_prev) begin
            rx_d.rise  = 1'b1;
            rx_d.shreg = {rx_d.shreg[BYTE_W-2:0], data_i};
            if (rx_d.bitcnt == LAST_BIT) begin
                rx_d.bvld   = 1'b1;
                rx_d.bdata  = rx_d.shreg;
                rx_d.bmode  = mode_i;
                rx_d.bitcnt = '0;
            end else begin
                rx_d.bitcnt = rx_d.bitcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rise_o  = rx_q.rise;
    assign phase_o = rx_q.phase;
    assign mode_o  = rx_q.mode_prev;
    assign bvld_o  = rx_q.bvld;
    assign byte_o  = rx_q.bdata;
    assign bmode_o = rx_q.bmode;

    // R11
    byte_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.bvld |-> rx_q.rise);

    // R11
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.phase |-> (rx_q.bitcnt <= BIT_CW'(1)));
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int REG_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic              phase_i,
    input  logic              mode_i,
    input  logic              bvld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              bmode_i,
    output logic              wr_en_o,
    output logic              rd_en_o,
    output logic [REG_AW-1:0] addr_o,
    output logic [REG_DW-1:0] wdata_o,
    output logic              drive_o
);
    localparam int DATA_BYTES = REG_DW / BYTE_W;
    localparam int CNT_W      = $clog2(DATA_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_BYTES);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(DATA_BYTES + 1);

    typedef struct packed {
        logic              sel;
        logic              rd;
        logic              dphase;
        logic [CNT_W-1:0]  cnt;
        logic [REG_AW-1:0] waddr;
        logic [REG_DW-1:0] acc;
        logic [REG_AW-1:0] ptr;
        logic              ptrv;
        logic              wr;
        logic              rde;
        logic [REG_AW-1:0] aout;
        logic [REG_DW-1:0] wdata;
    } ctrl_s;

    ctrl_s ct_d, ct_q;
    tw_op_e op;

    always_comb begin
        op        = tw_op_e'(byte_i[1:0]);
        ct_d      = ct_q;
        ct_d.wr   = 1'b0;
        ct_d.rde  = 1'b0;
        if (bvld_i) begin
            if (!bmode_i) begin
                ct_d.sel = (byte_i[BYTE_W-1 -: DEV_W] == dev_i) &&
                           (op == OP_WRPREP || op == OP_READ);
                ct_d.rd  = (op == OP_READ);
            end else if (ct_q.sel && !ct_q.rd && ct_q.dphase) begin
                if (ct_q.cnt == '0) begin
                    if (byte_i[BYTE_W-1]) begin
                        ct_d.ptr  = byte_i[REG_AW-1:0];
                        ct_d.ptrv = 1'b1;
                        ct_d.cnt  = CNT_DONE;
                    end else begin
                        ct_d.waddr = byte_i[REG_AW-1:0];
                        ct_d.cnt   = CNT_W'(1);
                    end
                end else if (ct_q.cnt != CNT_DONE) begin
                    ct_d.acc = {ct_q.acc[REG_DW-BYTE_W-1:0], byte_i};
                    if (ct_q.cnt == CNT_LAST) begin
                        ct_d.wr    = 1'b1;
                        ct_d.aout  = ct_q.waddr;
                        ct_d.wdata = ct_d.acc;
                    end
                    ct_d.cnt = ct_q.cnt + 1'b1;
                end
            end
        end
        if (phase_i) begin
            ct_d.cnt = '0;
            if (!mode_i) begin
                ct_d.sel    = 1'b0;
                ct_d.dphase = 1'b0;
            end else begin
                ct_d.dphase = 1'b1;
                if (ct_q.sel && ct_q.rd && ct_q.ptrv) begin
                    ct_d.rde  = 1'b1;
                    ct_d.aout = ct_q.ptr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign wr_en_o = ct_q.wr;
    assign rd_en_o = ct_q.rde;
    assign addr_o  = ct_q.aout;
    assign wdata_o = ct_q.wdata;
    assign drive_o = ct_q.sel && ct_q.rd && ct_q.dphase;

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ct_q.wr && ct_q.rde));

    // R4
    write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.wr |-> (ct_q.cnt == CNT_DONE));

    // R9
    write_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.wr |-> (ct_q.sel && !ct_q.rd));

    // R7
    read_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.rde |-> ct_q.ptrv);

    // R6
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.rde |=> !ct_q.rde);
endmodule

// File: rtl/tw_tx.sv
module tw_tx #(
    parameter int REG_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [REG_DW-1:0] ldata_i,
    input  logic              shift_i,
    output logic              bit_o
);
    typedef struct packed {
        logic [REG_DW-1:0] sh;
    } tx_s;

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (clr_i)        tx_d.sh = '0;
        else if (load_i)  tx_d.sh = ldata_i;
        else if (shift_i) tx_d.sh = {tx_q.sh[REG_DW-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign bit_o = tx_q.sh[REG_DW-1];

    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i && !clr_i) |=> (tx_q.sh[0] == 1'b0));
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
    import tw_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR    = 6'b101100,
    parameter int         REG_DW      = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              tw_clk,
    input  logic              tw_mode,
    input  logic              tw_din,
    output logic              tw_dout,
    output logic              tw_doe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [6:0]        reg_addr,
    output logic [REG_DW-1:0] reg_wdata,
    input  logic [REG_DW-1:0] reg_rdata
);
    logic [2:0]        lines_s;
    logic              rise, phase, mode, bvld, bmode;
    logic [BYTE_W-1:0] rx_byte;
    logic [DEV_W-1:0]  dev_eff;

    assign dev_eff = {DEV_ADDR[DEV_W-1:1], addr_sel};

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tw_clk, tw_mode, tw_din}),
        .sync_o  (lines_s)
    );

    tw_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (lines_s[2]),
        .mode_i  (lines_s[1]),
        .data_i  (lines_s[0]),
        .rise_o  (rise),
        .phase_o (phase),
        .mode_o  (mode),
        .bvld_o  (bvld),
        .byte_o  (rx_byte),
        .bmode_o (bmode)
    );

    tw_ctrl #(.REG_DW(REG_DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_i   (dev_eff),
        .phase_i (phase),
        .mode_i  (mode),
        .bvld_i  (bvld),
        .byte_i  (rx_byte),
        .bmode_i (bmode),
        .wr_en_o (reg_wr_en),
        .rd_en_o (reg_rd_en),
        .addr_o  (reg_addr),
        .wdata_o (reg_wdata),
        .drive_o (tw_doe)
    );

    tw_tx #(.REG_DW(REG_DW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (phase && mode),
        .load_i  (reg_rd_en),
        .ldata_i (reg_rdata),
        .shift_i (rise && mode),
        .bit_o   (tw_dout)
    );

    // R8
    drive_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_doe |-> $past(mode));
endmodule

// File: tb/tw_reg_slave_tb.sv
module tw_reg_slave_tb;
    localparam logic [5:0] DEV = 6'b101100;
    localparam int H   = 6;
    localparam int SET = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel = 1'b0;
    logic        tw_clk = 1'b0, tw_mode = 1'b0, tw_din = 1'b0;
    logic        tw_dout, tw_doe, reg_wr_en, reg_rd_en;
    logic [6:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    logic [15:0] bmem [128];
    logic [15:0] m_mem [128];
    logic [22:0] exp_wr [$];
    logic [6:0]  exp_rd [$];
    logic        m_sel = 0, m_rd = 0, m_ptrv = 0, oe_allowed = 0, done = 0;
    logic [6:0]  m_ptr = 0, m_wa = 0;
    logic [7:0]  m_hi = 0;
    int          m_cnt = 0, n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    tw_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .tw_clk(tw_clk), .tw_mode(tw_mode), .tw_din(tw_din),
        .tw_dout(tw_dout), .tw_doe(tw_doe),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = bmem[reg_addr];

    task automatic fail(string req, string what, int act, int exp);
        n_fail++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) fail(req, what, act, exp);
    endtask

    // strobe and drive monitor, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en) begin
                n_chk++;
                if (exp_wr.size() == 0) fail("R4", "unexpected write strobe", int'({reg_addr, reg_wdata}), 0);
                else begin
                    logic [22:0] e;
                    e = exp_wr.pop_front();
                    if ({reg_addr, reg_wdata} !== e) fail("R3", "write addr/data", int'({reg_addr, reg_wdata}), int'(e));
                end
                bmem[reg_addr] <= reg_wdata;
            end
            if (reg_rd_en) begin
                n_chk++;
                if (exp_rd.size() == 0) fail("R7", "unexpected read strobe", int'(reg_addr), 0);
                else begin
                    logic [6:0] e;
                    e = exp_rd.pop_front();
                    if (reg_addr !== e) fail("R6", "read strobe address", int'(reg_addr), int'(e));
                end
            end
            if (tw_doe) begin
                n_chk++;
                if (!oe_allowed) fail("R8", "doe outside read data phase", 1, 0);
            end
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(logic b);
        tw_din = b;
        wait_n(H);
        tw_clk = 1'b1;
        wait_n(H);
        tw_clk = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    endtask

    task automatic to_addr_mode();
        if (tw_mode) begin
            tw_mode = 1'b0;
            m_sel = 1'b0;
            wait_n(SET);
            oe_allowed = 1'b0;
            chk("R8", "doe after data phase", int'(tw_doe), 0);
            chk("R3", "writes left pending", exp_wr.size(), 0);
            chk("R6", "reads left pending", exp_rd.size(), 0);
        end
    endtask

    task automatic model_addr(logic [7:0] v);
        m_sel = (v[7:2] == {DEV[5:1], addr_sel}) && (v[1:0] == 2'b01 || v[1:0] == 2'b11);
        m_rd  = (v[1:0] == 2'b11);
    endtask

    task automatic addr_byte(logic [7:0] v);
        to_addr_mode();
        send_byte(v);
        model_addr(v);
    endtask

    task automatic enter_data();
        oe_allowed = m_sel && m_rd;
        m_cnt = 0;
        if (m_sel && m_rd && m_ptrv) exp_rd.push_back(m_ptr);
        tw_mode = 1'b1;
        wait_n(SET);
    endtask

    task automatic model_byte(logic [7:0] v);
        if (m_sel && !m_rd) begin
            if (m_cnt == 0) begin
                if (v[7]) begin m_ptr = v[6:0]; m_ptrv = 1'b1; m_cnt = 3; end
                else begin m_wa = v[6:0]; m_cnt = 1; end
            end else if (m_cnt == 1) begin
                m_hi = v; m_cnt = 2;
            end else if (m_cnt == 2) begin
                exp_wr.push_back({m_wa, m_hi, v});
                m_mem[m_wa] = {m_hi, v};
                m_cnt = 3;
            end
        end
    endtask

    task automatic data_byte(logic [7:0] v);
        model_byte(v);
        send_byte(v);
    endtask

    // mode rises on the same edge as the first bus-clock rise (R11)
    task automatic data_byte_coincident(logic [7:0] v);
        m_cnt = 0;
        oe_allowed = 1'b0;
        model_byte(v);
        tw_din = v[7];
        wait_n(H);
        tw_mode = 1'b1;
        tw_clk  = 1'b1;
        wait_n(H);
        tw_clk = 1'b0;
        for (int i = 6; i >= 0; i--) bus_bit(v[i]);
    endtask

    task automatic read_bits(int n, string req);
        logic [15:0] w;
        logic eoe;
        eoe = m_sel && m_rd;
        w = (eoe && m_ptrv) ? m_mem[m_ptr] : 16'h0;
        for (int i = 0; i < n; i++) begin
            wait_n(H);
            chk("R8", "doe during read bit", int'(tw_doe), int'(eoe));
            if (eoe) chk(req, "read data bit", int'(tw_dout), (i < 16) ? int'(w[15-i]) : 0);
            tw_clk = 1'b1;
            wait_n(H);
            tw_clk = 1'b0;
        end
    endtask

    task automatic write_reg(logic [6:0] a, logic [15:0] v);
        addr_byte({DEV[5:1], addr_sel, 2'b01});
        enter_data();
        data_byte({1'b0, a});
        data_byte(v[15:8]);
        data_byte(v[7:0]);
    endtask

    task automatic read_reg(logic [6:0] a, string req);
        addr_byte({DEV[5:1], addr_sel, 2'b01});
        enter_data();
        data_byte({1'b1, a});
        addr_byte({DEV[5:1], addr_sel, 2'b11});
        enter_data();
        read_bits(18, req);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            bmem[i]  = 16'hA000 ^ 16'(i * 311);
            m_mem[i] = 16'hA000 ^ 16'(i * 311);
        end
        wait_n(3);
        // R1 during reset
        chk("R1", "doe in reset", int'(tw_doe), 0);
        chk("R1", "wr_en in reset", int'(reg_wr_en), 0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1", "doe after reset", int'(tw_doe), 0);
        chk("R1", "rd_en after reset", int'(reg_rd_en), 0);

        // R7 read with no pointer stored
        addr_byte({DEV, 2'b11});
        enter_data();
        read_bits(16, "R7");

        // R3 plain write, R2 MSB-first address decode
        write_reg(7'h15, 16'hBEEF);
        // R4 extra bytes after a full write
        write_reg(7'h22, 16'h1234);
        data_byte(8'h56);
        data_byte(8'h78);
        // R5 prepare then extra bytes, no write
        addr_byte({DEV, 2'b01});
        enter_data();
        data_byte(8'h80 | 8'h15);
        data_byte(8'h11);
        data_byte(8'h22);
        // R6 read prepared pointer
        addr_byte({DEV, 2'b11});
        enter_data();
        read_bits(20, "R6");
        // R6 pointer persists for a second read
        addr_byte({DEV, 2'b11});
        enter_data();
        read_bits(16, "R6");
        read_reg(7'h22, "R4");
        read_reg(7'h40, "R6");

        // R9 mismatches and unused operation codes
        addr_byte({DEV ^ 6'b010000, 2'b01});
        enter_data();
        data_byte(8'h30); data_byte(8'hAA); data_byte(8'hBB);
        addr_byte({DEV ^ 6'b000100, 2'b11});
        enter_data();
        read_bits(8, "R9");
        addr_byte({DEV, 2'b00});
        enter_data();
        data_byte(8'h31); data_byte(8'h01); data_byte(8'h02);
        addr_byte({DEV, 2'b10});
        enter_data();
        data_byte(8'h31); data_byte(8'h03); data_byte(8'h04);
        addr_byte({DEV, 2'b10});
        enter_data();
        read_bits(4, "R9");

        // R2 address-select pin picks the lowest device bit
        addr_sel = 1'b1;
        write_reg(7'h31, 16'h0102);
        addr_byte({DEV[5:1], 1'b0, 2'b01});
        enter_data();
        data_byte(8'h31); data_byte(8'hDE); data_byte(8'hAD);
        read_reg(7'h31, "R2");
        addr_sel = 1'b0;

        // R10 selection dropped by an incomplete address phase
        addr_byte({DEV, 2'b01});
        enter_data();
        tw_mode = 1'b0;
        m_sel = 1'b0;
        wait_n(SET);
        oe_allowed = 1'b0;
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        enter_data();
        data_byte(8'h15); data_byte(8'h00); data_byte(8'h00);
        read_reg(7'h15, "R10");

        // R11 mode change coincident with first data bit
        addr_byte({DEV, 2'b01});
        data_byte_coincident(8'h05);
        data_byte(8'hCA);
        data_byte(8'hFE);
        read_reg(7'h05, "R11");
        to_addr_mode();
        wait_n(SET);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule